// File: doc/BRIEF.md
# Per-Chip Column Address Translator

This block models the column translation stage that each memory chip of a rank applies to the column address it receives on the shared command/address bus. Every chip gets the same command, column address and pattern selector. For a column read or a column write, each chip flips some low column bits according to its own position in the rank, so one command can gather or scatter a strided set of values that lie in different columns of different chips. For every other command, the address passes through unchanged.

The block holds one translator per chip, instantiated by a generate loop. A shared decoder decides whether the command translates. All per-chip results are captured in one register bank on the same clock edge. A valid flag leaves the block one cycle after the command-valid input, and the column registers load only when a command is valid.

Top module: `col_xlate_array`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is 0 and every chip's output column is 0 after that edge.
- R2: `out_valid` equals the value `cmd_valid` had at the previous clock edge (one cycle of latency).
- R3: For a valid READ (code 3'd2) or WRITE (code 3'd3), the column of chip k (held in `col_out[k*COL_W +: COL_W]`) becomes `addr XOR (k AND pattern)` one cycle later, with the mask in the low PAT_W bits. Chip 0 therefore always gets `addr`.
- R4: For a valid command of any other code, every chip's column becomes `addr` unchanged. This covers NOP 3'd0, ACT 3'd1, PRE 3'd4, REF 3'd5 and the unused codes 3'd6 and 3'd7.
- R5: With `pattern` equal to 0, a valid READ or WRITE gives every chip the same column, equal to `addr`.
- R6: Column bits at or above position PAT_W are never altered; each chip's upper bits equal those of `addr`.
- R7: When `cmd_valid` is low, every chip's column holds its previous value, whatever `cmd`, `addr` and `pattern` carry.
- R8: With `pattern` all ones (3'd7), a valid READ or WRITE places the 8 chips in 8 different columns for every base address. All 8 columns fall within the aligned group of 8 that contains `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | The command fields are valid this cycle |
| cmd | input | 3 | Command code |
| addr | input | COL_W (10) | Shared column address |
| pattern | input | PAT_W (3) | Pattern selector, masked by each chip ID |
| out_valid | output | 1 | Registered copy of `cmd_valid` |
| col_out | output | NUM_CHIPS*COL_W (80) | Per-chip column addresses; chip k occupies bits k*COL_W +: COL_W |

## Verification
The bench builds the block with its defaults: 8 chips, a 3-bit pattern and 10-bit columns. At this size every one of the 1024 base addresses can be swept under the all-ones pattern, so the distinct-column property is checked exhaustively rather than by sampling. The small pattern and command spaces also let the bench apply all 8 patterns and all 8 command codes, including the two unused ones, against a model written from the requirements.

// File: rtl/col_xlate_pkg.sv
// Package: shared command encoding for the column translator.
// Assumes a 3-bit command field; codes 6 and 7 are unassigned.
package col_xlate_pkg;
    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_REF   = 3'd5
    } cmd_e;
endpackage

// File: rtl/xlate_cmd_decode.sv
// Module: decides whether a command translates column addresses.
// Only column read and column write translate; every other code,
// including unassigned ones, is treated as pass-through.
module xlate_cmd_decode
    import col_xlate_pkg::*;
(
    input  logic [2:0] cmd_code,
    output logic       translate_en
);
    // Flag the two column-access commands.
    always_comb begin
        case (cmd_code)
            CMD_READ, CMD_WRITE: translate_en = 1'b1;
            default:             translate_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/chip_col_morph.sv
// Module: one chip's column morph. XORs the low PAT_W column bits
// with this chip's ID masked by the pattern when enabled.
// Assumes PAT_W < COL_W and CHIP_ID fits in PAT_W bits.
module chip_col_morph #(
    parameter int COL_W   = 10,
    parameter int PAT_W   = 3,
    parameter int CHIP_ID = 0
) (
    input  logic [COL_W-1:0] col_in,
    input  logic [PAT_W-1:0] pat,
    input  logic             translate_en,
    output logic [COL_W-1:0] col_xl
);
    localparam logic [PAT_W-1:0] ID_BITS = PAT_W'(CHIP_ID);

    logic [PAT_W-1:0] morph;

    // Build the mask and apply it to the low bits only.
    always_comb begin
        morph  = translate_en ? (ID_BITS & pat) : '0;
        col_xl = {col_in[COL_W-1:PAT_W], col_in[PAT_W-1:0] ^ morph};
    end
endmodule

// File: rtl/col_xlate_array.sv
// Module: rank-wide column translator, one morph unit per chip,
// with all results registered together and a valid flag delayed
// by one cycle. Columns load only on a valid command.
module col_xlate_array
    import col_xlate_pkg::*;
#(
    parameter int NUM_CHIPS = 8,
    parameter int COL_W     = 10,
    parameter int PAT_W     = $clog2(NUM_CHIPS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd,
    input  logic [COL_W-1:0]           addr,
    input  logic [PAT_W-1:0]           pattern,
    output logic                       out_valid,
    output logic [NUM_CHIPS*COL_W-1:0] col_out
);
    localparam int HI_W = COL_W - PAT_W;

    logic             xl_en;
    logic [COL_W-1:0] next_col [NUM_CHIPS];
    logic [COL_W-1:0] col_q    [NUM_CHIPS];

    xlate_cmd_decode u_dec (
        .cmd_code     (cmd),
        .translate_en (xl_en)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CHIPS; g++) begin : g_chip
            chip_col_morph #(
                .COL_W   (COL_W),
                .PAT_W   (PAT_W),
                .CHIP_ID (g)
            ) u_morph (
                .col_in       (addr),
                .pat          (pattern),
                .translate_en (xl_en),
                .col_xl       (next_col[g])
            );
            assign col_out[g*COL_W +: COL_W] = col_q[g];
        end
    endgenerate

    // Capture all chip columns together; hold them when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            for (int k = 0; k < NUM_CHIPS; k++) col_q[k] <= '0;
        end else begin
            out_valid <= cmd_valid;
            if (cmd_valid) begin
                for (int k = 0; k < NUM_CHIPS; k++) col_q[k] <= next_col[k];
            end
        end
    end

    // Assertions guarding the register bank.
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == cmd_valid |=> out_valid == $past(cmd_valid))
        else $error("R2 valid latency");

    generate
        for (g = 0; g < NUM_CHIPS; g++) begin : g_chk
            localparam logic [PAT_W-1:0] CID = PAT_W'(g);

            p_rw_morph_r3: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_valid && (cmd == CMD_READ || cmd == CMD_WRITE)
                |=> (col_q[g][PAT_W-1:0] ^ $past(addr[PAT_W-1:0])) == (CID & $past(pattern)))
                else $error("R3 morph chip %0d", g);

            p_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_valid && !(cmd == CMD_READ || cmd == CMD_WRITE)
                |=> col_q[g] == $past(addr))
                else $error("R4 pass-through chip %0d", g);

            p_default_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_valid && pattern == '0 |=> col_q[g] == $past(addr))
                else $error("R5 default map chip %0d", g);

            p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_valid |=> col_q[g][COL_W-1 -: HI_W] == $past(addr[COL_W-1 -: HI_W]))
                else $error("R6 upper bits chip %0d", g);

            p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !cmd_valid |=> $stable(col_q[g]))
                else $error("R7 hold chip %0d", g);
        end
    endgenerate
endmodule

// File: tb/tb_col_xlate_array.sv
// Bench: directed scenarios, one task each, checking at the ports.
module tb_col_xlate_array;
    localparam int NUM_CHIPS = 8;
    localparam int COL_W     = 10;
    localparam int PAT_W     = 3;

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic                       cmd_valid;
    logic [2:0]                 cmd;
    logic [COL_W-1:0]           addr;
    logic [PAT_W-1:0]           pattern;
    logic                       out_valid;
    logic [NUM_CHIPS*COL_W-1:0] col_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    col_xlate_array #(.NUM_CHIPS(NUM_CHIPS), .COL_W(COL_W), .PAT_W(PAT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .addr(addr), .pattern(pattern), .out_valid(out_valid), .col_out(col_out)
    );

    function automatic logic [COL_W-1:0] model(int k, logic [2:0] c,
                                               logic [COL_W-1:0] a, logic [PAT_W-1:0] p);
        if (c == 3'd2 || c == 3'd3)
            return a ^ COL_W'(PAT_W'(k) & p);
        return a;
    endfunction

    function automatic logic [COL_W-1:0] chip_col(int k);
        return col_out[k*COL_W +: COL_W];
    endfunction

    task automatic check(string req, logic [COL_W-1:0] act, logic [COL_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle between edges, then sample just after the edge.
    task automatic drive(logic v, logic [2:0] c, logic [COL_W-1:0] a, logic [PAT_W-1:0] p);
        @(negedge clk);
        cmd_valid = v; cmd = c; addr = a; pattern = p;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1'b0, 3'd2, 10'h3ff, 3'd7);
        drive(1'b0, 3'd2, 10'h3ff, 3'd7);
        check("R1 valid", COL_W'(out_valid), '0);
        for (int k = 0; k < NUM_CHIPS; k++) check("R1 column", chip_col(k), '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_valid_latency();
        drive(1'b1, 3'd0, 10'h011, 3'd0);
        check("R2 valid high", COL_W'(out_valid), 1);
        drive(1'b0, 3'd0, 10'h011, 3'd0);
        check("R2 valid low", COL_W'(out_valid), 0);
    endtask

    task automatic t_rw_morph();
        for (int p = 0; p < 8; p++) begin
            for (int rw = 2; rw <= 3; rw++) begin
                drive(1'b1, 3'(rw), 10'h2a5 + 10'(p * 37), 3'(p));
                for (int k = 0; k < NUM_CHIPS; k++)
                    check("R3 morph", chip_col(k), model(k, 3'(rw), addr, 3'(p)));
            end
        end
    endtask

    task automatic t_passthru();
        for (int c = 0; c < 8; c++) begin
            if (c == 2 || c == 3) continue;
            drive(1'b1, 3'(c), 10'h155 + 10'(c), 3'd7);
            for (int k = 0; k < NUM_CHIPS; k++)
                check("R4 pass-through", chip_col(k), addr);
        end
    endtask

    task automatic t_default_map();
        drive(1'b1, 3'd2, 10'h0c7, 3'd0);
        for (int k = 0; k < NUM_CHIPS; k++) check("R5 default", chip_col(k), 10'h0c7);
        drive(1'b1, 3'd3, 10'h3f8, 3'd0);
        for (int k = 0; k < NUM_CHIPS; k++) check("R5 default", chip_col(k), 10'h3f8);
    endtask

    task automatic t_upper_bits();
        drive(1'b1, 3'd3, 10'h3ff, 3'd7);
        for (int k = 0; k < NUM_CHIPS; k++) check("R6 upper", chip_col(k) >> PAT_W, 10'h3ff >> PAT_W);
    endtask

    task automatic t_hold();
        logic [COL_W-1:0] snap [NUM_CHIPS];
        drive(1'b1, 3'd2, 10'h123, 3'd5);
        for (int k = 0; k < NUM_CHIPS; k++) snap[k] = chip_col(k);
        drive(1'b0, 3'd3, 10'h2dd, 3'd7);
        for (int k = 0; k < NUM_CHIPS; k++) check("R7 hold", chip_col(k), snap[k]);
        drive(1'b0, 3'd0, 10'h000, 3'd0);
        for (int k = 0; k < NUM_CHIPS; k++) check("R7 hold", chip_col(k), snap[k]);
    endtask

    task automatic t_stride_distinct();
        for (int b = 0; b < (1 << COL_W); b++) begin
            logic [NUM_CHIPS-1:0] seen = '0;
            drive(1'b1, (b % 2) ? 3'd3 : 3'd2, COL_W'(b), 3'd7);
            for (int k = 0; k < NUM_CHIPS; k++) begin
                logic [COL_W-1:0] cv = chip_col(k);
                check("R8 group", cv >> PAT_W, COL_W'(b) >> PAT_W);
                seen[cv[PAT_W-1:0]] = 1'b1;
            end
            check("R8 distinct", COL_W'(seen), COL_W'({NUM_CHIPS{1'b1}}));
        end
    endtask

    initial begin
        cmd_valid = 1'b0; cmd = '0; addr = '0; pattern = '0; rst_n = 1'b0;
        t_reset();
        t_valid_latency();
        t_rw_morph();
        t_passthru();
        t_default_map();
        t_upper_bits();
        t_hold();
        t_stride_distinct();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule